// File: doc/BRIEF.md
# Host Register Port with Sample Capture Handshake

This block is the host-facing register file of a signal-processing channel. A host processor reaches sixteen byte-wide locations through a 4-bit address, a read/write select (high means read), an active-low strobe and an 8-bit data bus. The bus is split at this boundary into an input half, an output half and a drive-enable, so that the pad ring can build the tristate driver. The strobe, select and address are resynchronised to the block clock. Each strobe pulse with the select low commits exactly one write. While the strobe is low with the select high, the block drives the addressed register onto the bus.

Locations 0 to 8 are plain configuration bytes and are exported to the rest of the channel. Location 9 holds the capture handshake. The host sets the ready bit to request a sample. The next valid I/Q pair from the datapath is latched into four read-only bytes (12 to 15), and the hardware then clears ready. A sticky missed bit records samples that arrive while nobody asked for one. An active-low interrupt follows ready when enabled. Writing anything to location 10 fires a one-clock active-low sync pulse. In real output mode the datapath presents even-time samples on the I word and odd-time samples on the Q word, so the same capture holds one even/odd pair.

Top module: `host_regfile_capture`

## Requirements
- R1: A write commits when the synchronised strobe falls while the select is low. It loads bus_in into the addressed location. The new value is visible on the outputs after the third rising edge that follows the strobe falling, and each strobe pulse commits at most one write.
- R2: rd_oe is high only while the strobe is low and the select is high, delayed by two clocks. rd_data then shows the addressed location. Locations 0 to 8 read back what was written, and locations 10 and 11 read as zero.
- R3: With ready (status bit 0) set, a valid sample is captured into the readback locations: 12 holds I[7:0], 13 holds I[15:8], 14 holds Q[7:0] and 15 holds Q[15:8]. Both words are taken on the same edge, and ready clears on that edge. Writes to 12 to 15 are ignored.
- R4: A valid sample that arrives while ready is low leaves locations 12 to 15 unchanged and sets missed (status bit 1).
- R5: Writing 0 to status bit 1 clears missed, and writing 1 to it leaves missed unchanged. So 0x01 sets ready and clears missed, and 0x03 sets ready and keeps missed.
- R6: int_n is low exactly when ready and the interrupt-enable bit (status bit 2) are both 1.
- R7: Any write to location 10 drives pulse_n low for exactly one clock, whatever the data. It changes no other location.
- R8: If a capture and a status write that sets ready happen on the same edge, the sample is captured and ready stays set.
- R9: While rst_n is low on a rising edge, every location clears to zero and int_n and pulse_n are high.
- R10: cfg_o carries configuration location k in bits [8k+7:8k] for k = 0 to 8. Status bits 7 to 3 are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_n | input | 1 | Host access strobe, active low |
| rd_sel | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Host location address |
| bus_in | input | 8 | Host bus, data driven by the host |
| rd_data | output | 8 | Host bus, data driven by the block |
| rd_oe | output | 1 | Drive enable for rd_data |
| samp_valid | input | 1 | Datapath sample qualifier |
| samp_i | input | 16 | In-phase (or even-time) sample word |
| samp_q | input | 16 | Quadrature (or odd-time) sample word |
| int_n | output | 1 | Interrupt, active low |
| pulse_n | output | 1 | One-clock sync pulse, active low |
| cfg_o | output | 72 | Configuration locations 0 to 8 |

## Verification
Host inputs change on falling edges. A write takes effect after the third rising edge that follows the strobe falling, and a read enable or read value appears after the second. A sample presented before an edge is acted on at that edge. The bench's reference model keeps a queue of pending writes, each stamped with the edge index on which it is due. It also keeps a two-deep history of the read request, and it updates its state at every rising edge from the inputs that were stable before that edge. All outputs are compared with the model at every falling edge. That is also where the explicit checks sample, so each result is read one half-period after the edge that produced it.

// File: rtl/host_pkg.sv
package host_pkg;
    localparam int DW        = 8;
    localparam int AW        = 4;
    localparam int SW        = 16;
    localparam int NCFG      = 9;
    localparam int LOC_STAT  = 9;
    localparam int LOC_PULSE = 10;
    localparam int LOC_I_LO  = 12;
    localparam int LOC_I_HI  = 13;
    localparam int LOC_Q_LO  = 14;
    localparam int LOC_Q_HI  = 15;

    typedef struct packed {
        logic [4:0] spare;
        logic       irq_en;
        logic       missed;
        logic       ready;
    } status_t;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
    parameter int AW = host_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_n_i,
    input  logic          rd_sel_i,
    input  logic [AW-1:0] addr_i,
    output logic          rd_req_o,
    output logic [AW-1:0] addr_o,
    output logic          wr_fire_o
);
    typedef struct packed {
        logic          stb1;
        logic          stb2;
        logic          stb_prev;
        logic          sel1;
        logic          sel2;
        logic [AW-1:0] adr1;
        logic [AW-1:0] adr2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.stb1     = strobe_n_i;
        st_d.stb2     = st_q.stb1;
        st_d.stb_prev = st_q.stb2;
        st_d.sel1     = rd_sel_i;
        st_d.sel2     = st_q.sel1;
        st_d.adr1     = addr_i;
        st_d.adr2     = st_q.adr1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.stb1     <= 1'b1;
            st_q.stb2     <= 1'b1;
            st_q.stb_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_o  = !st_q.stb2 && st_q.sel2;
    assign addr_o    = st_q.adr2;
    assign wr_fire_o = st_q.stb_prev && !st_q.stb2 && !st_q.sel2;

    // R1: one strobe pulse yields a single commit cycle
    p_single_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire_o |=> !wr_fire_o);
endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import host_pkg::*;
#(
    parameter int SW_P = host_pkg::SW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stat_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            samp_valid_i,
    input  logic [SW_P-1:0] samp_i_i,
    input  logic [SW_P-1:0] samp_q_i,
    output status_t         status_o,
    output logic [SW_P-1:0] i_word_o,
    output logic [SW_P-1:0] q_word_o
);
    typedef struct packed {
        status_t         stat;
        logic [SW_P-1:0] iw;
        logic [SW_P-1:0] qw;
    } cap_t;

    cap_t cs_d, cs_q;
    logic take, lost;

    always_comb begin
        cs_d = cs_q;
        take = samp_valid_i && cs_q.stat.ready;
        lost = samp_valid_i && !cs_q.stat.ready;
        if (take) begin
            cs_d.iw = samp_i_i;
            cs_d.qw = samp_q_i;
            cs_d.stat.ready = 1'b0;
        end
        if (wr_stat_i) begin
            cs_d.stat.ready  = wdata_i[0];
            cs_d.stat.irq_en = wdata_i[2];
            cs_d.stat.spare  = wdata_i[7:3];
            if (!wdata_i[1]) cs_d.stat.missed = 1'b0;
        end
        if (lost) cs_d.stat.missed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign status_o = cs_q.stat;
    assign i_word_o = cs_q.iw;
    assign q_word_o = cs_q.qw;

    // R3: a taken sample disarms the handshake unless the host rearms
    p_take_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid_i && status_o.ready && !wr_stat_i) |=> !status_o.ready);
    // R3: both words come from the same edge
    p_pair_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid_i && status_o.ready) |=>
        (i_word_o == $past(samp_i_i) && q_word_o == $past(samp_q_i)));
    // R4: readback holds when no sample is taken
    p_hold_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_valid_i && status_o.ready) |=> ($stable(i_word_o) && $stable(q_word_o)));
    // R5: missed only clears through an explicit zero write
    p_missed_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o.missed && !(wr_stat_i && !wdata_i[1])) |=> status_o.missed);
    // R8: a rearm on the take edge keeps ready set
    p_rearm_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_i && wdata_i[0]) |=> status_o.ready);
endmodule

// File: rtl/host_regfile_capture.sv
module host_regfile_capture
    import host_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_n,
    input  logic               rd_sel,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      bus_in,
    output logic [DW-1:0]      rd_data,
    output logic               rd_oe,
    input  logic               samp_valid,
    input  logic [SW-1:0]      samp_i,
    input  logic [SW-1:0]      samp_q,
    output logic               int_n,
    output logic               pulse_n,
    output logic [NCFG*DW-1:0] cfg_o
);
    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] cfg;
        logic                    pulse_n;
    } top_t;

    top_t          tp_d, tp_q;
    logic          rd_req, wr_fire, wr_stat;
    logic [AW-1:0] addr_s;
    status_t       stat;
    logic [SW-1:0] i_word, q_word;

    host_sync #(.AW(AW)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n_i(strobe_n),
        .rd_sel_i  (rd_sel),
        .addr_i    (addr),
        .rd_req_o  (rd_req),
        .addr_o    (addr_s),
        .wr_fire_o (wr_fire)
    );

    assign wr_stat = wr_fire && (addr_s == AW'(LOC_STAT));

    cap_unit #(.SW_P(SW)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stat_i   (wr_stat),
        .wdata_i     (bus_in),
        .samp_valid_i(samp_valid),
        .samp_i_i    (samp_i),
        .samp_q_i    (samp_q),
        .status_o    (stat),
        .i_word_o    (i_word),
        .q_word_o    (q_word)
    );

    always_comb begin
        tp_d         = tp_q;
        tp_d.pulse_n = !(wr_fire && (addr_s == AW'(LOC_PULSE)));
        for (int k = 0; k < NCFG; k++) begin
            if (wr_fire && (addr_s == AW'(k))) tp_d.cfg[k] = bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q         <= '0;
            tp_q.pulse_n <= 1'b1;
        end else begin
            tp_q <= tp_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NCFG; k++) begin
            if (addr_s == AW'(k)) rd_data = tp_q.cfg[k];
        end
        if (addr_s == AW'(LOC_STAT)) rd_data = stat;
        if (addr_s == AW'(LOC_I_LO)) rd_data = i_word[7:0];
        if (addr_s == AW'(LOC_I_HI)) rd_data = i_word[SW-1:8];
        if (addr_s == AW'(LOC_Q_LO)) rd_data = q_word[7:0];
        if (addr_s == AW'(LOC_Q_HI)) rd_data = q_word[SW-1:8];
    end

    assign rd_oe   = rd_req;
    assign int_n   = !(stat.ready && stat.irq_en);
    assign pulse_n = tp_q.pulse_n;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        assign cfg_o[g*DW +: DW] = tp_q.cfg[g];
    end

    // R7: the sync pulse never lasts beyond one clock
    p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_n |=> pulse_n);
    // R6: interrupt never asserted without an armed request
    p_irq_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> stat.ready);
    // R2: the bus is driven only during a read request
    p_drive_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(!strobe_n && rd_sel, 2));
endmodule

// File: tb/host_regfile_capture_test.sv
module host_regfile_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_n = 1'b1;
    logic        rd_sel = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  rd_data;
    logic        rd_oe;
    logic        samp_valid = 1'b0;
    logic [15:0] samp_i = '0;
    logic [15:0] samp_q = '0;
    logic        int_n;
    logic        pulse_n;
    logic [71:0] cfg_o;

    host_regfile_capture uut (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .rd_sel(rd_sel),
        .addr(addr), .bus_in(bus_in), .rd_data(rd_data), .rd_oe(rd_oe),
        .samp_valid(samp_valid), .samp_i(samp_i), .samp_q(samp_q),
        .int_n(int_n), .pulse_n(pulse_n), .cfg_o(cfg_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int low_pulses = 0;

    typedef struct {
        int         due;
        logic [3:0] a;
        logic [7:0] d;
    } wr_t;
    wr_t wq[$];

    logic [7:0]  m_cfg [9];
    logic        m_ready, m_missed, m_ie;
    logic [4:0]  m_spare;
    logic [15:0] m_i, m_q;
    logic        m_pulse_n;
    logic        h1_oe, h2_oe;
    logic [3:0]  h1_a, h2_a;

    function automatic logic [7:0] m_read(input logic [3:0] a);
        if (a < 9)  return m_cfg[a];
        if (a == 9) return {m_spare, m_ie, m_missed, m_ready};
        if (a == 12) return m_i[7:0];
        if (a == 13) return m_i[15:8];
        if (a == 14) return m_q[7:0];
        if (a == 15) return m_q[15:8];
        return 8'h00;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 9; k++) m_cfg[k] = '0;
        m_ready = 0; m_missed = 0; m_ie = 0; m_spare = '0;
        m_i = '0; m_q = '0; m_pulse_n = 1;
        h1_oe = 0; h2_oe = 0; h1_a = '0; h2_a = '0;
    endtask

    initial model_clear();

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            model_clear();
            wq.delete();
        end else begin
            logic       wr;
            logic [3:0] wa;
            logic [7:0] wd;
            logic       take, lost, nready, nmissed;
            wr = 0; wa = '0; wd = '0;
            if (wq.size() > 0 && wq[0].due == cyc) begin
                wr = 1; wa = wq[0].a; wd = wq[0].d;
                void'(wq.pop_front());
            end
            take = samp_valid && m_ready;
            lost = samp_valid && !m_ready;
            if (take) begin m_i = samp_i; m_q = samp_q; end
            nready  = take ? 1'b0 : m_ready;
            nmissed = m_missed;
            if (wr && wa == 9) begin
                nready = wd[0]; m_ie = wd[2]; m_spare = wd[7:3];
                if (!wd[1]) nmissed = 0;
            end
            if (lost) nmissed = 1;
            m_ready = nready; m_missed = nmissed;
            if (wr && wa < 9) m_cfg[wa] = wd;
            m_pulse_n = !(wr && wa == 10);
            h2_oe = h1_oe; h2_a = h1_a;
            h1_oe = !strobe_n && rd_sel; h1_a = addr;
        end
    end

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison, half a period after each edge
    always @(negedge clk) begin
        logic [71:0] ecfg;
        if (rst_n) begin
            for (int k = 0; k < 9; k++) ecfg[k*8 +: 8] = m_cfg[k];
            chk("R10 cfg_o", cfg_o, ecfg);
            chk("R6 int_n", int_n, !(m_ready && m_ie));
            chk("R7 pulse_n", pulse_n, m_pulse_n);
            chk("R2 rd_oe", rd_oe, h2_oe);
            if (h2_oe) chk("R2 rd_data", rd_data, m_read(h2_a));
            if (!pulse_n) low_pulses++;
        end
    end

    task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
        wr_t e;
        @(negedge clk);
        addr = a; rd_sel = 0; bus_in = d; strobe_n = 0;
        e.due = cyc + 3; e.a = a; e.d = d;
        wq.push_back(e);
        repeat (4) @(negedge clk);
        strobe_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic host_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_sel = 1; strobe_n = 0;
        repeat (3) @(negedge clk);
        chk(tag, {rd_oe, rd_data}, {1'b1, exp});
        strobe_n = 1; rd_sel = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic push_samp(input logic [15:0] i, input logic [15:0] q);
        @(negedge clk);
        samp_valid = 1; samp_i = i; samp_q = q;
        @(negedge clk);
        samp_valid = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int p0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 cfg_o", cfg_o, 72'h0);
        chk("R9 int_n", int_n, 1'b1);
        chk("R9 pulse_n", pulse_n, 1'b1);
        rst_n = 1;
        repeat (3) @(negedge clk);
        host_rd(4'd9, 8'h00, "R9 status after reset");

        // R1 / R10: configuration bytes
        for (int k = 0; k < 9; k++) host_wr(4'(k), 8'(8'h31 * (k + 1) ^ 8'h5A));
        for (int k = 0; k < 9; k++) host_rd(4'(k), 8'(8'h31 * (k + 1) ^ 8'h5A), "R1 cfg readback");
        chk("R10 cfg byte 4", cfg_o[39:32], 8'(8'h31 * 5 ^ 8'h5A));
        host_rd(4'd10, 8'h00, "R2 loc10 reads zero");
        host_rd(4'd11, 8'h00, "R2 loc11 reads zero");

        // R3: readback locations ignore writes
        host_wr(4'd12, 8'hEE);
        host_wr(4'd15, 8'hDD);
        host_rd(4'd12, 8'h00, "R3 write to 12 ignored");
        host_rd(4'd15, 8'h00, "R3 write to 15 ignored");

        // R4: unrequested sample
        push_samp(16'hBEEF, 16'hCAFE);
        host_rd(4'd12, 8'h00, "R4 no capture when unarmed");
        host_rd(4'd9, 8'h02, "R4 missed set");

        // R6 / R3: armed capture with interrupt enabled; 0x07 keeps missed
        host_wr(4'd9, 8'h07);
        chk("R6 int low while armed", int_n, 1'b0);
        push_samp(16'h1234, 16'hA5C3);
        @(negedge clk);
        chk("R6 int high after capture", int_n, 1'b1);
        host_rd(4'd12, 8'h34, "R3 I low");
        host_rd(4'd13, 8'h12, "R3 I high");
        host_rd(4'd14, 8'hC3, "R3 Q low");
        host_rd(4'd15, 8'hA5, "R3 Q high");
        host_rd(4'd9, 8'h06, "R3 ready cleared");

        // R5: 0x03 keeps missed, 0x01 clears it
        host_wr(4'd9, 8'h03);
        host_rd(4'd9, 8'h03, "R5 0x03 keeps missed");
        host_wr(4'd9, 8'h01);
        host_rd(4'd9, 8'h01, "R5 0x01 clears missed");
        chk("R6 int high when disabled", int_n, 1'b1);

        // R3: back-to-back samples, only the first one taken
        @(negedge clk);
        samp_valid = 1; samp_i = 16'h0F0F; samp_q = 16'hF0F0;
        @(negedge clk);
        samp_i = 16'h7777; samp_q = 16'h8888;
        @(negedge clk);
        samp_valid = 0;
        host_rd(4'd13, 8'h0F, "R3 first of burst kept");
        host_rd(4'd9, 8'h02, "R4 burst tail missed");

        // R7: one-shot pulse
        p0 = low_pulses;
        host_wr(4'd10, 8'hFF);
        chk("R7 one low cycle", low_pulses - p0, 1);
        chk("R7 cfg untouched", cfg_o[7:0], 8'(8'h31 ^ 8'h5A));

        // R8: rearm on the same edge as a capture
        host_wr(4'd9, 8'h05);
        begin
            wr_t e;
            @(negedge clk);
            addr = 4'd9; rd_sel = 0; bus_in = 8'h05; strobe_n = 0;
            e.due = cyc + 3; e.a = 4'd9; e.d = 8'h05;
            wq.push_back(e);
            repeat (2) @(negedge clk);
            samp_valid = 1; samp_i = 16'h4321; samp_q = 16'h8765;
            @(negedge clk);
            samp_valid = 0;
            @(negedge clk);
            strobe_n = 1;
            repeat (3) @(negedge clk);
        end
        host_rd(4'd12, 8'h21, "R8 sample taken");
        host_rd(4'd9, 8'h05, "R8 ready stays set");
        chk("R8 int low", int_n, 1'b0);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule